// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Controller

This block walks a linked list of 32-byte DMA descriptors kept in system memory. Software places a chain of descriptors in memory, marks each one as owned by hardware, loads the address of the first one into the next-descriptor register and sets the start bit. The controller then fetches each descriptor, passes its addresses, length and flags to an external data mover, and writes the byte count and error status that come back into the descriptor. It then follows the descriptor's link to the next entry.

A descriptor that hardware does not own ends the chain. In re-poll mode the controller instead waits a programmed number of clocks and reads the same descriptor again, so software can append work to a running chain. Sticky status flags and a single interrupt line report errors, end-of-packet, each completed descriptor, the end of the chain, and the point at which a programmed number of descriptors have completed. A control-register bit gives a software reset.

Top module: `sgchain_ctrl`

## Requirements
- R1: A descriptor at byte address A is read as words: read address at A+0, write address at A+8, next pointer at A+16, and at A+24 a word whose bits 15:0 are the length. The word at A+28 is read first. Its bits 31:24 are the descriptor control byte: bit 0 end-of-packet, bit 1 fixed read address, bit 2 fixed write address, bit 7 hardware-owned. The mover receives the read address, write address, length and mv_flags = control byte bits 2:0. Memory and mover requests are never active together.
- R2: CSR addresses are 0 for status, 1 for control and 2 for next pointer. Status bits are 0 error, 1 end-of-packet, 2 descriptor done, 3 chain done and 4 busy. Writing control with bit 5 set while idle starts processing at the next-pointer address and sets busy.
- R3: When a fetched descriptor has control bit 7 clear and re-poll is off, busy clears, chain done (status bit 3) sets and no transfer is issued. While idle, neither memory nor mover requests are made.
- R4: After each transfer, the word at A+28 is written as {control byte, mover status, mover byte count} in bits 31:24, 23:16 and 15:0. Control bit 7 is cleared in that write when CSR control bit 17 is 0 and kept when it is 1.
- R5: After a writeback, the next-pointer register takes the descriptor's next pointer and fetching continues at that address.
- R6: Error sets on mover status bit 0. End-of-packet sets when the descriptor's control bit 0 or the mover's status bit 7 is set. Descriptor done sets on each writeback. All stay set until control is written with bit 31 set, or until a software reset.
- R7: irq is control bit 4 ANDed with the OR of: bit 0 and error, bit 1 and end-of-packet, bit 2 and descriptor done, bit 3 and chain done, bit 7 and count reached.
- R8: The count is reached when the number of descriptors completed since the last interrupt clear equals control bits 15:8, which must be non-zero.
- R9: With control bit 6 set, a transfer that returns mover status bit 0 stops the controller after its writeback. Busy clears, chain done stays clear, and the next pointer is left at the failing descriptor.
- R10: With control bit 18 set, a non-owned descriptor is re-read every N+2 clocks, where N is control bits 26:19, and busy stays set. Clearing bit 18 while waiting ends the chain with chain done set.
- R11: Writing control with bit 16 set returns to idle and clears control, status and the interrupt. Control bits 16 and 31 always read as 0.
- R12: mem_req holds its address, direction and data until mem_ack. mv_req holds until mv_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 2 | CSR word select |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory access complete |
| mv_req | output | 1 | Transfer request to data mover |
| mv_raddr | output | 32 | Transfer source address |
| mv_waddr | output | 32 | Transfer destination address |
| mv_len | output | 16 | Transfer length in bytes |
| mv_flags | output | 3 | {fixed write, fixed read, end-of-packet} |
| mv_done | input | 1 | Transfer complete |
| mv_bytes | input | 16 | Bytes transferred |
| mv_status | input | 8 | Transfer status byte |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is re-poll: the controller must sit on a descriptor it does not own and keep re-reading it at the programmed interval. The bench then has to change memory under it. The bench starts on an unowned descriptor with re-poll on, counts the reads of its completion word over a fixed window, and then sets the ownership bit in its memory model while polling continues. It checks that the transfer and the writeback follow. Two further cases are built from the same model: the descriptor-count interrupt, which spans two runs of the chain with no interrupt clear between them, and stop-on-error with a second owned descriptor left in memory.

// File: rtl/sgchain_ctrl.sv
module sgchain_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_we,
  input  logic [1:0]  csr_addr,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack,
  output logic        mv_req,
  output logic [31:0] mv_raddr,
  output logic [31:0] mv_waddr,
  output logic [15:0] mv_len,
  output logic [2:0]  mv_flags,
  input  logic        mv_done,
  input  logic [15:0] mv_bytes,
  input  logic [7:0]  mv_status,
  output logic        irq
);
  localparam int B_IE_ERR  = 0;
  localparam int B_IE_EOP  = 1;
  localparam int B_IE_DESC = 2;
  localparam int B_IE_LAST = 3;
  localparam int B_IE_ALL  = 4;
  localparam int B_GO      = 5;
  localparam int B_HALTERR = 6;
  localparam int B_IE_CNT  = 7;
  localparam int B_SRST    = 16;
  localparam int B_KEEPOWN = 17;
  localparam int B_REPOLL  = 18;
  localparam int B_ACK     = 31;
  localparam logic [31:0] CTL_MASK = 32'h7FFE_FFFF;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_MOVE, S_WB, S_POLL} state_t;

  state_t      st;
  logic [2:0]  k;
  logic [31:0] cur, nxt, ctl, raddr, waddr, dnext;
  logic [15:0] len, mbytes;
  logic [7:0]  dctl, mstat, pcnt, dcnt;
  logic [3:0]  sts;
  logic        maxhit;
  logic        busy, ctl_wr;
  logic [2:0]  wsel;

  assign busy   = (st != S_IDLE);
  assign ctl_wr = csr_we && (csr_addr == 2'd1);
  assign wsel   = (st == S_WB || k == 3'd0) ? 3'd7 : {k[1:0] - 2'd1, 1'b0};

  assign mem_req   = (st == S_FETCH) || (st == S_WB);
  assign mem_we    = (st == S_WB);
  assign mem_addr  = cur + {27'd0, wsel, 2'b00};
  assign mem_wdata = {ctl[B_KEEPOWN] ? dctl : {1'b0, dctl[6:0]}, mstat, mbytes};

  assign mv_req   = (st == S_MOVE);
  assign mv_raddr = raddr;
  assign mv_waddr = waddr;
  assign mv_len   = len;
  assign mv_flags = dctl[2:0];

  assign irq = ctl[B_IE_ALL] & ((ctl[B_IE_ERR] & sts[0]) | (ctl[B_IE_EOP] & sts[1]) |
               (ctl[B_IE_DESC] & sts[2]) | (ctl[B_IE_LAST] & sts[3]) | (ctl[B_IE_CNT] & maxhit));

  always_comb begin
    case (csr_addr)
      2'd0:    csr_rdata = {27'd0, busy, sts};
      2'd1:    csr_rdata = ctl;
      2'd2:    csr_rdata = nxt;
      default: csr_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; k <= '0; cur <= '0; nxt <= '0; ctl <= '0;
      raddr <= '0; waddr <= '0; dnext <= '0; len <= '0; mbytes <= '0;
      dctl <= '0; mstat <= '0; pcnt <= '0; dcnt <= '0; sts <= '0; maxhit <= 1'b0;
    end else begin
      if (ctl_wr) begin
        ctl <= csr_wdata & CTL_MASK;
        if (csr_wdata[B_ACK]) begin
          sts <= '0; maxhit <= 1'b0; dcnt <= '0;
        end
      end
      if (csr_we && csr_addr == 2'd2 && st == S_IDLE) nxt <= csr_wdata;

      case (st)
        S_IDLE:
          if (ctl_wr && csr_wdata[B_GO]) begin
            st <= S_FETCH; k <= '0; cur <= nxt;
          end
        S_FETCH:
          if (mem_ack) begin
            case (k)
              3'd0: begin
                dctl <= mem_rdata[31:24];
                if (mem_rdata[31]) k <= 3'd1;
                else if (ctl[B_REPOLL]) begin
                  st <= S_POLL; pcnt <= ctl[26:19];
                end else begin
                  st <= S_IDLE; sts[3] <= 1'b1;
                end
              end
              3'd1: begin raddr <= mem_rdata; k <= 3'd2; end
              3'd2: begin waddr <= mem_rdata; k <= 3'd3; end
              3'd3: begin dnext <= mem_rdata; k <= 3'd4; end
              default: begin len <= mem_rdata[15:0]; st <= S_MOVE; end
            endcase
          end
        S_MOVE:
          if (mv_done) begin
            mbytes <= mv_bytes;
            mstat  <= mv_status;
            if (mv_status[0]) sts[0] <= 1'b1;
            if (dctl[0] || mv_status[7]) sts[1] <= 1'b1;
            st <= S_WB;
          end
        S_WB:
          if (mem_ack) begin
            sts[2] <= 1'b1;
            dcnt   <= dcnt + 8'd1;
            if (ctl[15:8] != 8'd0 && dcnt + 8'd1 == ctl[15:8]) maxhit <= 1'b1;
            if (ctl[B_HALTERR] && mstat[0]) st <= S_IDLE;
            else begin
              cur <= dnext; nxt <= dnext; k <= '0; st <= S_FETCH;
            end
          end
        S_POLL:
          if (!ctl[B_REPOLL]) begin
            st <= S_IDLE; sts[3] <= 1'b1;
          end else if (pcnt == 8'd0) begin
            st <= S_FETCH; k <= '0;
          end else pcnt <= pcnt - 8'd1;
        default: st <= S_IDLE;
      endcase

      if (ctl_wr && csr_wdata[B_SRST]) begin
        st <= S_IDLE; ctl <= '0; sts <= '0; maxhit <= 1'b0; dcnt <= '0;
      end
    end
  end
endmodule

// File: rtl/sgchain_ctrl_chk.sv
module sgchain_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        csr_we,
  input logic [1:0]  csr_addr,
  input logic [31:0] csr_wdata,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mv_req,
  input logic        mv_done,
  input logic        irq,
  input logic        busy,
  input logic [31:0] ctl
);
  logic srst_wr;
  assign srst_wr = csr_we && csr_addr == 2'd1 && csr_wdata[16];

  p_mem_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && !srst_wr |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  p_mv_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mv_req && !mv_done && !srst_wr |=> mv_req);

  p_excl_r1: assert property (@(posedge clk) disable iff (!rst_n) !(mem_req && mv_req));

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !mv_req);

  p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n) !ctl[4] |-> !irq);

  p_own_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && !ctl[17] |-> !mem_wdata[31]);

  p_srst_r11: assert property (@(posedge clk) disable iff (!rst_n)
    srst_wr |=> !busy && !irq && ctl == 32'd0);
endmodule

bind sgchain_ctrl sgchain_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mv_req(mv_req), .mv_done(mv_done), .irq(irq),
  .busy(busy), .ctl(ctl)
);

// File: tb/sgchain_ctrl_bench.sv
module sgchain_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csr_we = 1'b0;
  logic [1:0] csr_addr = 2'd0;
  logic [31:0] csr_wdata = 32'd0;
  logic [31:0] csr_rdata;
  logic mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = 32'd0;
  logic mem_ack = 1'b0;
  logic mv_req;
  logic [31:0] mv_raddr, mv_waddr;
  logic [15:0] mv_len;
  logic [2:0] mv_flags;
  logic mv_done = 1'b0;
  logic [15:0] mv_bytes = 16'd0;
  logic [7:0] mv_status = 8'd0;
  logic irq;

  always #5 clk = ~clk;

  sgchain_ctrl u_sgchain_ctrl (.*);

  logic [31:0] mem [0:63];
  int checks = 0, fails = 0, nwb = 0, nrd7 = 0, nmoves = 0, mcnt = 0;
  logic [7:0] stat_cfg = 8'd0;
  logic [31:0] cap_r, cap_w;
  logic [15:0] cap_len;
  logic [2:0] cap_fl;
  bit finished = 0;

  // rows: {keep_own, flags[2:0], mover status[7:0], length[15:0]}
  localparam logic [27:0] VEC [5] = '{
    {1'b0, 3'b000, 8'h00, 16'd10},
    {1'b1, 3'b001, 8'h00, 16'd64},
    {1'b0, 3'b110, 8'h01, 16'hFFFF},
    {1'b0, 3'b000, 8'h80, 16'd1},
    {1'b1, 3'b011, 8'h3F, 16'h1234}
  };

  initial forever begin
    @(negedge clk);
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (mem_we) begin
        mem[mem_addr[7:2]] = mem_wdata; nwb++;
      end else begin
        mem_rdata = mem[mem_addr[7:2]];
        if (mem_addr[4:0] == 5'd28) nrd7++;
      end
      mem_ack = 1'b1;
    end
  end

  initial forever begin
    @(negedge clk);
    if (mv_done) begin
      mv_done = 1'b0; mcnt = 0;
    end else if (mv_req) begin
      if (mcnt == 3) begin
        cap_r = mv_raddr; cap_w = mv_waddr; cap_len = mv_len; cap_fl = mv_flags;
        mv_bytes = mv_len; mv_status = stat_cfg; mv_done = 1'b1; nmoves++;
      end else mcnt++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic csr_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic csr_read(input logic [1:0] a, output logic [31:0] d);
    csr_addr = a; #1; d = csr_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); csr_read(2'd0, s);
      if (!s[4]) return;
    end
    chk("busy timeout", 32'd1, 32'd0);
  endtask

  task automatic mkdesc(input int w, input logic [31:0] ra, input logic [31:0] wa,
                        input logic [31:0] nx, input logic [15:0] ln, input logic [7:0] c);
    mem[w] = ra; mem[w+1] = 32'hA5A5_0001; mem[w+2] = wa; mem[w+3] = 32'hA5A5_0003;
    mem[w+4] = nx; mem[w+5] = 32'hA5A5_0005; mem[w+6] = {8'h04, 8'h04, ln};
    mem[w+7] = {c, 8'h00, 16'h0000};
  endtask

  task automatic own_chain3();
    mkdesc(0, 32'h100, 32'h200, 32'd32, 16'd4, 8'h80);
    mkdesc(8, 32'h110, 32'h210, 32'd64, 16'd5, 8'h80);
    mkdesc(16, 32'h120, 32'h220, 32'd96, 16'd6, 8'h80);
    mkdesc(24, 32'h0, 32'h0, 32'd0, 16'd0, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < 64; i++) mem[i] = 32'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    csr_read(2'd0, d); chk("R2 reset status", d, 32'd0);
    csr_read(2'd1, d); chk("R11 reset control", d, 32'd0);
    csr_read(2'd2, d); chk("R5 reset next", d, 32'd0);
    chk("R7 reset irq", {31'd0, irq}, 32'd0);
    chk("R3 reset requests", {30'd0, mem_req, mv_req}, 32'd0);

    for (int i = 0; i < 5; i++) begin
      logic [27:0] v;
      logic [7:0] c, ce;
      v = VEC[i];
      c = {5'b10000, v[26:24]};
      ce = v[27] ? c : {1'b0, c[6:0]};
      mkdesc(0, 32'h1000 + i, 32'h2000 + i, 32'd32, v[15:0], c);
      mkdesc(8, 32'h0, 32'h0, 32'd0, 16'd0, 8'h00);
      stat_cfg = v[23:16];
      csr_write(2'd2, 32'd0);
      csr_write(2'd1, (32'(v[27]) << 17) | 32'h8000_0020);
      wait_idle();
      chk("R4 writeback word", mem[7], {ce, v[23:16], v[15:0]});
      csr_read(2'd0, d);
      chk("R6 status flags", d, {28'd0, 1'b1, 1'b1, v[24] | v[23], v[16]});
      chk("R1 mover addresses", {cap_r[15:0], cap_w[15:0]}, {16'h1000 + 16'(i), 16'h2000 + 16'(i)});
      chk("R1 mover len/flags", {13'd0, cap_fl, cap_len}, {13'd0, v[26:24], v[15:0]});
      csr_read(2'd2, d); chk("R5 next after run", d, 32'd32);
    end

    // chain of three, count threshold 4 spans two runs
    own_chain3();
    stat_cfg = 8'h00;
    nwb = 0;
    csr_write(2'd2, 32'd0);
    csr_write(2'd1, 32'h8000_0000);
    csr_write(2'd1, 32'h0000_04B0);
    csr_read(2'd0, d); chk("R2 busy after start", {31'd0, d[4]}, 32'd1);
    wait_idle();
    chk("R5 three writebacks", nwb, 32'd3);
    csr_read(2'd2, d); chk("R5 next at chain end", d, 32'd96);
    chk("R3 chain end status", {28'd0, d[3:0]} & 32'h0, 32'h0);
    csr_read(2'd0, d); chk("R3 chain done bit", {31'd0, d[3]}, 32'd1);
    chk("R8 below threshold", {31'd0, irq}, 32'd0);
    chk("R4 owner cleared", {31'd0, mem[23][31]}, 32'd0);
    own_chain3();
    csr_write(2'd2, 32'd0);
    csr_write(2'd1, 32'h0000_04B0);
    wait_idle();
    chk("R8 threshold reached", {31'd0, irq}, 32'd1);
    csr_write(2'd1, 32'h0000_0018);
    chk("R7 chain-end irq", {31'd0, irq}, 32'd1);
    csr_write(2'd1, 32'h8000_0018);
    csr_read(2'd0, d); chk("R6 cleared by ack", d, 32'd0);
    chk("R7 irq cleared", {31'd0, irq}, 32'd0);

    // stop on error
    own_chain3();
    stat_cfg = 8'h01;
    nmoves = 0;
    csr_write(2'd2, 32'd0);
    csr_write(2'd1, 32'h8000_0060);
    wait_idle();
    chk("R9 one transfer", nmoves, 32'd1);
    chk("R9 second untouched", {31'd0, mem[15][31]}, 32'd1);
    csr_read(2'd0, d); chk("R9 status", d, 32'h5);
    csr_read(2'd2, d); chk("R9 next kept", d, 32'd0);
    csr_write(2'd1, 32'h0000_0011);
    chk("R7 error irq", {31'd0, irq}, 32'd1);
    csr_write(2'd1, 32'h0000_0001);
    chk("R7 global gate", {31'd0, irq}, 32'd0);
    csr_write(2'd1, 32'h0000_0014);
    chk("R7 per-descriptor irq", {31'd0, irq}, 32'd1);

    // re-poll
    stat_cfg = 8'h00;
    mkdesc(0, 32'h300, 32'h400, 32'd32, 16'd8, 8'h00);
    mkdesc(8, 32'h0, 32'h0, 32'd0, 16'd0, 8'h00);
    csr_write(2'd2, 32'd0);
    csr_write(2'd1, 32'h8000_0000);
    csr_write(2'd1, (32'd6 << 19) | 32'h0004_0020);
    nrd7 = 0; nwb = 0;
    repeat (80) @(negedge clk);
    chk("R10 poll interval", {31'd0, nrd7 >= 9 && nrd7 <= 11}, 32'd1);
    csr_read(2'd0, d); chk("R10 busy while polling", {27'd0, d[4:0]}, 32'h10);
    mem[7] = {8'h80, 24'd0};
    repeat (40) @(negedge clk);
    chk("R10 owned after poll", nwb, 32'd1);
    csr_read(2'd2, d); chk("R10 moved on", d, 32'd32);
    csr_write(2'd1, 32'h0000_0000);
    @(negedge clk);
    csr_read(2'd0, d); chk("R10 exit poll", d, 32'h0C);

    // soft reset while polling
    csr_write(2'd1, (32'd6 << 19) | 32'h0004_0020);
    repeat (10) @(negedge clk);
    csr_write(2'd1, 32'h0001_0000);
    csr_read(2'd0, d); chk("R11 status cleared", d, 32'd0);
    csr_read(2'd1, d); chk("R11 control cleared", d, 32'd0);
    chk("R11 idle requests", {30'd0, mem_req, mv_req}, 32'd0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule